// File: doc/BRIEF.md
# Variable-Frequency Current-Reset PWM Generator

This block is a single-channel pulse-width modulator with its own time base. A programmed period gives the longest a cycle can last. A programmed duty gives the length of the on phase at the start of each cycle. An external restart strobe can end a cycle early and start the next one. The strobe typically comes from a comparator that detects when inductor current has fallen below a threshold. The on-time stays fixed, and the switching frequency follows the load.

The block drives a primary output and its complement. A mode input swaps the two, so that the duty value sets the off time of the primary output. In that case the drive is described as constant off-time rather than constant on-time.

The external strobe is first resynchronized to the clock. Only its rising edge is used, and only when the counter has already passed the duty point of the current cycle. New period and duty values take effect only when a cycle starts. This is true whether the cycle started by wrap or by external restart. A one-clock pulse marks every cycle start.

Top module: `vfreq_pwm`

## Requirements
- R1: While `enable` is low, and during reset, `count` is 0 and `pwmHi`, `pwmLo` and `cycleStart` are 0. At the first clock edge that samples `enable` high, a cycle starts: during the following clock `count` is 0 and `cycleStart` is 1.
- R2: With no external restart, `count` steps by one each clock from 0 up to the latched period P. It then returns to 0 at the next edge, so a cycle lasts P+1 clocks.
- R3: With `offTimeMode` = 0 and the block running, `pwmHi` is 1 exactly while `count` is below the latched duty D. `pwmLo` is always the inverse of `pwmHi`.
- R4: With `offTimeMode` = 1 and the block running, `pwmHi` is 0 exactly while `count` is below D, and 1 otherwise. `pwmLo` is its inverse.
- R5: A rising edge on `extResetIn` passes through a two-flop synchronizer and an edge detector. If `extResetIn` rises while `count` shows c, a restart occurs at the third clock edge after the rise, provided c+2 ≥ D and c+2 ≤ P. The cycle then lasts c+3 clocks.
- R6: An external edge that reaches the edge detector while `count` is below D is ignored. The cycle runs to its full length, and an input level that stays high afterwards causes no late restart.
- R7: Only rising edges act. If `extResetIn` is held high across a restart, the following cycle runs its full P+1 clocks.
- R8: `periodIn` and `dutyIn` are captured only at a cycle start. Changes made in mid-cycle affect neither the current cycle's length nor its output.
- R9: `cycleStart` is high for exactly one clock after each restart, whether caused by wrap, external edge or enable. `count` is 0 in that clock.
- R10: No cycle lasts longer than P+1 clocks, and `count` never exceeds the latched period while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low holds it idle |
| periodIn | input | CNT_W | Maximum cycle length minus one, captured at cycle start |
| dutyIn | input | CNT_W | On-phase length in clocks, captured at cycle start |
| extResetIn | input | 1 | Asynchronous early-restart request, rising-edge active |
| offTimeMode | input | 1 | 1 swaps primary and complementary outputs |
| pwmHi | output | 1 | Primary PWM output |
| pwmLo | output | 1 | Complementary PWM output |
| count | output | CNT_W | Current time-base value |
| cycleStart | output | 1 | One-clock pulse at each cycle start |

## Verification
On every cycle, the assertions check the following:
- the counter never passes the latched period;
- the two outputs stay complementary while running;
- latched settings change only on a restart strobe;
- an edge seen during the on phase never produces a start pulse;
- the counter reads zero whenever the start pulse is high;
- the block is idle one clock after enable drops.

Only the bench scenarios can show the following:
- the exact cycle lengths produced by wrap across swept period, duty and mode;
- the three-edge latency from the external strobe to the restart;
- the absence of restarts from a held level;
- that mid-cycle setting changes have no effect until the next start.

// File: rtl/vfreq_pwm_pkg.sv
package vfreq_pwm_pkg;

  // Strobes from the control unit to the counter datapath.
  typedef struct packed {
    logic run;      // a cycle is in progress
    logic restart;  // clear the counter and capture new settings
    logic advance;  // step the counter by one
  } pwm_strobe_t;

endpackage

// File: rtl/vfreq_pwm_sync.sv
module vfreq_pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/vfreq_pwm_ctrl.sv
module vfreq_pwm_ctrl
  import vfreq_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        extSync,
  input  logic        atPeriod,
  input  logic        offPhase,
  output pwm_strobe_t strb,
  output logic        cycleStart
);

  logic running;
  logic extPrev;
  logic extEdge;
  logic wrapHit;
  logic extHit;
  logic restart;

  assign extEdge = extSync & ~extPrev;
  assign wrapHit = running & atPeriod;
  assign extHit  = running & extEdge & offPhase;
  assign restart = enable & (~running | wrapHit | extHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      extPrev    <= 1'b0;
      cycleStart <= 1'b0;
    end else begin
      running    <= enable;
      extPrev    <= extSync;
      cycleStart <= restart;
    end
  end

  always_comb begin
    strb         = '0;
    strb.run     = running;
    strb.restart = restart;
    strb.advance = enable & running & ~restart;
  end

  // An edge during the on phase, away from wrap, must not start a cycle.
  AST_EXT_IGNORED_ON: assert property (@(posedge clk) disable iff (!rstN)
    (running && enable && extEdge && !offPhase && !atPeriod) |=> !cycleStart); // R6

  // A start pulse can only follow a clock where enable was high.
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |-> $past(enable)); // R9

endmodule

// File: rtl/vfreq_pwm_dp.sv
module vfreq_pwm_dp
  import vfreq_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwm_strobe_t      strb,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic             offTimeMode,
  output logic [CNT_W-1:0] count,
  output logic             atPeriod,
  output logic             offPhase,
  output logic             pwmHi,
  output logic             pwmLo
);

  logic [CNT_W-1:0] activePeriod;
  logic [CNT_W-1:0] activeDuty;
  logic             onPhase;
  logic             drive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count        <= '0;
      activePeriod <= '0;
      activeDuty   <= '0;
    end else if (strb.restart) begin
      count        <= '0;
      activePeriod <= periodIn;
      activeDuty   <= dutyIn;
    end else if (strb.advance) begin
      count <= count + 1'b1;
    end else begin
      count <= '0;
    end
  end

  assign atPeriod = (count == activePeriod);
  assign offPhase = (count >= activeDuty);
  assign onPhase  = ~offPhase;
  assign drive    = onPhase ^ offTimeMode;
  assign pwmHi    = strb.run & drive;
  assign pwmLo    = strb.run & ~drive;

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (count <= activePeriod)); // R10

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (pwmHi != pwmLo)); // R3

  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    !strb.restart |=> ($stable(activePeriod) && $stable(activeDuty))); // R8

endmodule

// File: rtl/vfreq_pwm.sv
module vfreq_pwm
  import vfreq_pwm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic             extResetIn,
  input  logic             offTimeMode,
  output logic             pwmHi,
  output logic             pwmLo,
  output logic [CNT_W-1:0] count,
  output logic             cycleStart
);

  pwm_strobe_t strb;
  logic        extSync;
  logic        atPeriod;
  logic        offPhase;

  vfreq_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extResetIn),
    .syncOut (extSync)
  );

  vfreq_pwm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .extSync    (extSync),
    .atPeriod   (atPeriod),
    .offPhase   (offPhase),
    .strb       (strb),
    .cycleStart (cycleStart)
  );

  vfreq_pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .periodIn    (periodIn),
    .dutyIn      (dutyIn),
    .offTimeMode (offTimeMode),
    .count       (count),
    .atPeriod    (atPeriod),
    .offPhase    (offPhase),
    .pwmHi       (pwmHi),
    .pwmLo       (pwmLo)
  );

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |-> (count == '0)); // R9

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (count == '0 && !pwmHi && !pwmLo && !cycleStart)); // R1

endmodule

// File: tb/vfreq_pwm_bench.sv
module vfreq_pwm_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] periodIn = '0;
  logic [CNT_W-1:0] dutyIn = '0;
  logic             extResetIn = 1'b0;
  logic             offTimeMode = 1'b0;
  logic             pwmHi;
  logic             pwmLo;
  logic [CNT_W-1:0] count;
  logic             cycleStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vfreq_pwm #(.CNT_W(CNT_W)) u_vfreq_pwm (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .periodIn    (periodIn),
    .dutyIn      (dutyIn),
    .extResetIn  (extResetIn),
    .offTimeMode (offTimeMode),
    .pwmHi       (pwmHi),
    .pwmLo       (pwmLo),
    .count       (count),
    .cycleStart  (cycleStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStart();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!cycleStart && guard < 600);
    check(cycleStart, "R9 start pulse seen", cycleStart, 1);
  endtask

  // Entered at a negedge where cycleStart is high; returns the cycle length.
  task automatic measure(input int duty, input bit mode, input int extAt, output int len);
    string tag;
    bit expHi;
    tag = mode ? "R4" : "R3";
    len = 0;
    forever begin
      expHi = (len < duty) ^ mode;
      check(int'(count) == len, "R2 count value", int'(count), len);
      check(pwmHi == expHi, {tag, " pwmHi"}, pwmHi, expHi);
      check(pwmLo == !expHi, {tag, " pwmLo"}, pwmLo, !expHi);
      if (len == extAt) extResetIn = 1'b1;
      len++;
      @(negedge clk);
      if (cycleStart || len > 600) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    int n;
    int exp;

    // R1: reset and idle state
    repeat (3) @(negedge clk);
    check(count == 0 && !pwmHi && !pwmLo && !cycleStart, "R1 reset state",
          {pwmHi, pwmLo, cycleStart}, 0);
    rstN = 1'b1;
    periodIn = 8'd6;
    dutyIn = 8'd2;
    repeat (4) @(negedge clk);
    check(count == 0 && !pwmHi && !pwmLo && !cycleStart, "R1 idle while disabled",
          int'(count), 0);
    enable = 1'b1;
    @(negedge clk);
    check(cycleStart == 1'b1, "R1 start pulse after enable", cycleStart, 1);
    check(count == 0, "R1 count zero at start", int'(count), 0);
    measure(2, 1'b0, -1, len);
    check(len == 7, "R2 first cycle length", len, 7);

    // R2 R3 R4: sweep period, duty and mode with no external restart
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 8; p++) begin
        for (int d = 0; d < 10; d++) begin
          offTimeMode = m[0];
          periodIn = p[CNT_W-1:0];
          dutyIn = d[CNT_W-1:0];
          waitStart();
          measure(d, m[0], -1, len);
          check(len == p + 1, "R2 wrap cycle length", len, p + 1);
        end
      end
    end
    offTimeMode = 1'b0;

    // R5 R6 R10: external restart at every count position
    periodIn = 8'd12;
    for (int di = 0; di < 3; di++) begin
      int d;
      d = (di == 0) ? 2 : ((di == 1) ? 5 : 9);
      dutyIn = d[CNT_W-1:0];
      for (int c = 0; c <= 10; c++) begin
        extResetIn = 1'b0;
        waitStart();
        measure(d, 1'b0, c, len);
        exp = (c + 2 >= d) ? c + 3 : 13;
        if (c + 2 >= d) check(len == exp, "R5 early restart length", len, exp);
        else check(len == exp, "R6 ignored edge in on phase", len, exp);
        check(len <= 13, "R10 cycle not longer than period", len, 13);
        extResetIn = 1'b0;
      end
    end

    // R7: held level restarts only once
    dutyIn = 8'd2;
    extResetIn = 1'b0;
    waitStart();
    measure(2, 1'b0, 4, len);
    check(len == 7, "R7 first restart", len, 7);
    measure(2, 1'b0, -1, len);
    check(len == 13, "R7 held level gives no second restart", len, 13);
    extResetIn = 1'b0;
    repeat (4) @(negedge clk);

    // R8: settings changed mid-cycle apply only at the next start
    periodIn = 8'd10;
    dutyIn = 8'd3;
    waitStart();
    waitStart();
    while (count != 4) @(negedge clk);
    periodIn = 8'd5;
    dutyIn = 8'd8;
    @(negedge clk);
    check(pwmHi == 1'b0, "R8 duty unchanged mid-cycle", pwmHi, 0);
    n = 5;
    while (!cycleStart && n < 600) begin
      @(negedge clk);
      n++;
    end
    check(n == 11, "R8 period unchanged mid-cycle", n, 11);
    measure(8, 1'b0, -1, len);
    check(len == 6, "R8 new period after start", len, 6);

    // R1: disable returns to idle
    enable = 1'b0;
    @(negedge clk);
    check(count == 0 && !pwmHi && !pwmLo && !cycleStart, "R1 idle after disable",
          int'(count), 0);
    repeat (3) @(negedge clk);
    check(count == 0 && !pwmHi && !pwmLo, "R1 stays idle", {pwmHi, pwmLo}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule